// File: doc/BRIEF.md
# Byte-Memory Boot Loader DMA

This block copies program code from a byte-wide external memory into the internal 24-bit program memory. After a reset with both boot-mode inputs low it starts on its own. It keeps the processor core stalled and reads bytes one at a time, stretching each read by a programmable number of wait cycles. Each group of three bytes becomes one program word, and it writes 32 such words starting at internal address 0. When the last word is written it releases the core, signals a restart at program address zero, and leaves an interrupt pending.

Software can run further transfers through a small register port. It sets the internal start address, the external byte address, the wait count and the context-reset bit, and then writes a nonzero word count. The context-reset bit decides whether the transfer stalls the core and ends in a restart, or lets the core keep running and only raises the interrupt. The word-type, direction and page fields are stored and read back but have no effect. Only 24-bit loads from byte memory within one page are performed.

Top module: `bytemem_boot_dma`

## Requirements
- R1: A reset with `boot_mode` equal to 2'b00 loads these values:
  - word count 32, internal address 0, external address 0;
  - wait count 7, context-reset bit 1;
  - word-type, direction and page all 0.
  In addition `core_hold` is 1 and a boot transfer begins once reset is released.
- R2: A reset with any nonzero `boot_mode` loads a word count of 0 and drives `core_hold` to 0. No memory access follows until software starts a transfer.
- R3: Each byte read holds `ext_rd` high for exactly wait+1 cycles at a constant `ext_addr`. The byte is taken in the last of those cycles, and `ext_addr` then advances by one.
- R4: Three consecutive bytes are packed first-byte-most-significant into `pm_wdata`. This word is written with a one-cycle `pm_we` in the cycle after the third byte, at `pm_addr` equal to the internal address register. The internal address then rises by one and the word count falls by one.
- R5: After the reset boot, the internal address reads 0x20, the external address reads 0x60 and the word count reads 0.
- R6: At the end of a transfer that holds the core, these happen in the same cycle:
  - `core_hold` falls;
  - `core_restart` pulses for one cycle, meaning execution restarts at program address 0x0000;
  - `irq_pend` rises.
- R7: Writing a nonzero word count while idle starts a transfer.
  - With the context-reset bit at 1, `core_hold` rises with the write and stays high for the whole transfer.
  - With the bit at 0, `core_hold` stays low, no restart pulse occurs, and only `irq_pend` is raised at the end.
- R8: Register writes while a transfer is running are ignored. Writing a word count of 0 while idle starts nothing.
- R9: A one-cycle `irq_ack` clears `irq_pend`. A completion in the same cycle wins over the acknowledge.
- R10: The register map on `cfg_addr` has six entries. Reads on `cfg_rdata` are combinational and zero-extended.

  | Address | Content |
  |---|---|
  | 0 | internal address |
  | 1 | external address |
  | 2 | control: bit 0 word type, bit 1 direction, bits 9:2 page |
  | 3 | wait count, bits 2:0 |
  | 4 | word count |
  | 5 | context-reset bit, bit 0 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_mode | input | 2 | Boot selection, 2'b00 selects a boot from byte memory |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data |
| ext_addr | output | 16 | Byte memory address |
| ext_data | input | 8 | Byte memory read data |
| ext_rd | output | 1 | Byte memory read strobe |
| pm_addr | output | 14 | Program memory write address |
| pm_wdata | output | 24 | Program memory write data |
| pm_we | output | 1 | Program memory write enable |
| core_hold | output | 1 | Stalls the processor core |
| core_restart | output | 1 | One-cycle pulse: core restarts at address 0 |
| irq_pend | output | 1 | Transfer-done interrupt pending |
| irq_ack | input | 1 | Clears the pending interrupt |

## Verification
Some properties are checked by assertions on every cycle:
- a read strobe and a program write never coincide, and each write follows a byte read;
- every byte and word step moves the address and the count by exactly one;
- the core is held only while a transfer is active;
- a restart pulse always ends a held period;
- every completion leaves the interrupt pending;
- register writes during a transfer leave the counters untouched.

Other behaviour only the bench scenarios can show: the exact strobe length for each wait setting, the packed word contents against a byte-memory model, the final register values after the boot, and the reset-mode selection. The difference between held and unheld software transfers is also shown by the scenarios.

// File: rtl/boot_dma_pkg.sv
// Shared definitions for the byte-memory boot loader.
// Assumes a single clock domain; register addresses are fixed by the map in the brief.
package boot_dma_pkg;
    localparam logic [2:0] RA_INT   = 3'd0;
    localparam logic [2:0] RA_EXT   = 3'd1;
    localparam logic [2:0] RA_CTRL  = 3'd2;
    localparam logic [2:0] RA_WAIT  = 3'd3;
    localparam logic [2:0] RA_COUNT = 3'd4;
    localparam logic [2:0] RA_CTX   = 3'd5;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_READ,
        FS_WRITE
    } fetch_state_t;
endpackage

// File: rtl/boot_dma_regs.sv
// Register file of the boot loader: addresses, count, wait, context bit and
// the inert type/direction/page fields. Software writes are accepted only
// while idle; the fetch engine steps the addresses and count while busy.
module boot_dma_regs
    import boot_dma_pkg::*;
#(
    parameter int DW         = 16,
    parameter int IAW        = 14,
    parameter int EAW        = 16,
    parameter int CW         = 14,
    parameter int WW         = 3,
    parameter int PGW        = 8,
    parameter int BOOT_WORDS = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     boot_mode,
    input  logic           cfg_wr,
    input  logic [2:0]     cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    output logic [DW-1:0]  cfg_rdata,
    input  logic           byte_done,
    input  logic           word_done,
    output logic [IAW-1:0] int_addr,
    output logic [EAW-1:0] ext_addr,
    output logic [WW-1:0]  wait_st,
    output logic           ctx_reset,
    output logic           busy,
    output logic           last_word,
    output logic           sw_start
);
    logic [CW-1:0]  wcount;
    logic           wtype;
    logic           wdir;
    logic [PGW-1:0] page;
    logic           wr_ok;

    assign busy      = (wcount != '0);
    assign last_word = (wcount == CW'(1));
    assign wr_ok     = cfg_wr && !busy;
    assign sw_start  = wr_ok && (cfg_addr == RA_COUNT) && (cfg_wdata[CW-1:0] != '0);

    // Register updates: reset boot values, idle software writes, engine steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_addr  <= '0;
            ext_addr  <= '0;
            wait_st   <= '1;
            ctx_reset <= 1'b1;
            wtype     <= 1'b0;
            wdir      <= 1'b0;
            page      <= '0;
            wcount    <= (boot_mode == 2'b00) ? CW'(BOOT_WORDS) : '0;
        end else begin
            if (wr_ok) begin
                case (cfg_addr)
                    RA_INT:   int_addr  <= cfg_wdata[IAW-1:0];
                    RA_EXT:   ext_addr  <= cfg_wdata[EAW-1:0];
                    RA_CTRL:  begin
                        wtype <= cfg_wdata[0];
                        wdir  <= cfg_wdata[1];
                        page  <= cfg_wdata[PGW+1:2];
                    end
                    RA_WAIT:  wait_st   <= cfg_wdata[WW-1:0];
                    RA_COUNT: wcount    <= cfg_wdata[CW-1:0];
                    RA_CTX:   ctx_reset <= cfg_wdata[0];
                    default:  ;
                endcase
            end
            if (byte_done) ext_addr <= ext_addr + EAW'(1);
            if (word_done) begin
                int_addr <= int_addr + IAW'(1);
                wcount   <= wcount - CW'(1);
            end
        end
    end

    // Read multiplexer, zero-extended.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            RA_INT:   cfg_rdata[IAW-1:0] = int_addr;
            RA_EXT:   cfg_rdata[EAW-1:0] = ext_addr;
            RA_CTRL:  cfg_rdata[PGW+1:0] = {page, wdir, wtype};
            RA_WAIT:  cfg_rdata[WW-1:0]  = wait_st;
            RA_COUNT: cfg_rdata[CW-1:0]  = wcount;
            RA_CTX:   cfg_rdata[0]       = ctx_reset;
            default:  cfg_rdata = '0;
        endcase
    end

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> wcount == $past(wcount) - CW'(1)); // R4
    AST_EXT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> ext_addr == $past(ext_addr) + EAW'(1)); // R3
    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && busy && !byte_done && !word_done) |=>
            ($stable(ext_addr) && $stable(int_addr) && $stable(wcount))); // R8
endmodule

// File: rtl/boot_dma_fetch.sv
// Fetch engine: reads bytes with wait-state stretching, packs three bytes
// first-most-significant and issues one program-memory write per word.
// Assumes wait_st is stable while busy (register writes are blocked then).
module boot_dma_fetch
    import boot_dma_pkg::*;
#(
    parameter int WW = 3,
    parameter int PW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          last_word,
    input  logic [WW-1:0] wait_st,
    input  logic [7:0]    ext_data,
    output logic          ext_rd,
    output logic          pm_we,
    output logic [PW-1:0] pm_wdata,
    output logic          byte_done,
    output logic          word_done
);
    localparam int BYTES = PW / 8;
    localparam int BIW   = $clog2(BYTES);

    fetch_state_t   state;
    logic [WW-1:0]  cnt;
    logic [BIW-1:0] bidx;
    logic [PW-1:0]  pack;

    assign ext_rd    = (state == FS_READ);
    assign byte_done = ext_rd && (cnt == wait_st);
    assign pm_we     = (state == FS_WRITE);
    assign word_done = pm_we;
    assign pm_wdata  = pack;

    // Sequencer: idle, stretched byte reads, single-cycle word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FS_IDLE;
            cnt   <= '0;
            bidx  <= '0;
            pack  <= '0;
        end else begin
            case (state)
                FS_IDLE: if (busy) begin
                    state <= FS_READ;
                    cnt   <= '0;
                    bidx  <= '0;
                end
                FS_READ: if (byte_done) begin
                    cnt  <= '0;
                    pack <= {pack[PW-9:0], ext_data};
                    if (bidx == BIW'(BYTES - 1)) begin
                        bidx  <= '0;
                        state <= FS_WRITE;
                    end else begin
                        bidx <= bidx + BIW'(1);
                    end
                end else begin
                    cnt <= cnt + WW'(1);
                end
                FS_WRITE: state <= last_word ? FS_IDLE : FS_READ;
                default:  state <= FS_IDLE;
            endcase
        end
    end

    AST_RD_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_rd && pm_we)); // R4
    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        pm_we |-> $past(ext_rd)); // R4
endmodule

// File: rtl/boot_dma_ctl.sv
// Core gating and completion: holds the core during gated transfers, pulses
// a restart at completion and keeps the done interrupt pending until acked.
module boot_dma_ctl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] boot_mode,
    input  logic       sw_start,
    input  logic       ctx_reset,
    input  logic       finish,
    input  logic       busy,
    input  logic       irq_ack,
    output logic       core_hold,
    output logic       core_restart,
    output logic       irq_pend
);
    // Hold, restart pulse and interrupt state; completion beats acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_hold    <= (boot_mode == 2'b00);
            core_restart <= 1'b0;
            irq_pend     <= 1'b0;
        end else begin
            core_restart <= 1'b0;
            if (sw_start && ctx_reset) core_hold <= 1'b1;
            if (finish) begin
                irq_pend <= 1'b1;
                if (core_hold) begin
                    core_hold    <= 1'b0;
                    core_restart <= 1'b1;
                end
            end else if (irq_ack) begin
                irq_pend <= 1'b0;
            end
        end
    end

    AST_HOLD_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        core_hold |-> busy); // R7
    AST_RESTART_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        core_restart |-> $past(core_hold)); // R6
    AST_IRQ_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> irq_pend); // R9
    AST_NO_HOLD_WITHOUT_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_start && !ctx_reset && !core_hold) |=> !core_hold); // R7
endmodule

// File: rtl/bytemem_boot_dma.sv
// Top of the byte-memory boot loader: register file, fetch engine and core
// gating control. Assumes the byte memory answers combinationally to ext_addr.
module bytemem_boot_dma #(
    parameter int DW         = 16,
    parameter int IAW        = 14,
    parameter int EAW        = 16,
    parameter int CW         = 14,
    parameter int WW         = 3,
    parameter int PW         = 24,
    parameter int BOOT_WORDS = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     boot_mode,
    input  logic           cfg_wr,
    input  logic [2:0]     cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    output logic [DW-1:0]  cfg_rdata,
    output logic [EAW-1:0] ext_addr,
    input  logic [7:0]     ext_data,
    output logic           ext_rd,
    output logic [IAW-1:0] pm_addr,
    output logic [PW-1:0]  pm_wdata,
    output logic           pm_we,
    output logic           core_hold,
    output logic           core_restart,
    output logic           irq_pend,
    input  logic           irq_ack
);
    logic          byte_done;
    logic          word_done;
    logic [WW-1:0] wait_st;
    logic          ctx_reset;
    logic          busy;
    logic          last_word;
    logic          sw_start;
    logic          finish;

    assign finish = word_done && last_word;

    boot_dma_regs #(
        .DW(DW), .IAW(IAW), .EAW(EAW), .CW(CW), .WW(WW), .PGW(8),
        .BOOT_WORDS(BOOT_WORDS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .byte_done(byte_done), .word_done(word_done),
        .int_addr(pm_addr), .ext_addr(ext_addr), .wait_st(wait_st),
        .ctx_reset(ctx_reset), .busy(busy), .last_word(last_word),
        .sw_start(sw_start)
    );

    boot_dma_fetch #(.WW(WW), .PW(PW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .busy(busy), .last_word(last_word),
        .wait_st(wait_st), .ext_data(ext_data), .ext_rd(ext_rd),
        .pm_we(pm_we), .pm_wdata(pm_wdata), .byte_done(byte_done),
        .word_done(word_done)
    );

    boot_dma_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .sw_start(sw_start),
        .ctx_reset(ctx_reset), .finish(finish), .busy(busy),
        .irq_ack(irq_ack), .core_hold(core_hold),
        .core_restart(core_restart), .irq_pend(irq_pend)
    );
endmodule

// File: tb/bytemem_boot_dma_test.sv
// Self-checking bench: a computed byte-memory model, a monitor checking
// strobe lengths and packed words, directed and random transfers.
module bytemem_boot_dma_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  boot_mode = 2'b00;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] cfg_rdata;
    logic [15:0] ext_addr;
    logic [7:0]  ext_data;
    logic        ext_rd;
    logic [13:0] pm_addr;
    logic [23:0] pm_wdata;
    logic        pm_we;
    logic        core_hold;
    logic        core_restart;
    logic        irq_pend;
    logic        irq_ack = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] salt = 8'h00;

    // Expected-state bookkeeping shared with the monitor.
    int          exp_wait = 7;
    logic [13:0] exp_int = '0;
    logic [15:0] exp_ext = '0;
    int          widx = 0;
    int          restart_cnt = 0;
    bit          hold_seen = 0;
    bit          run_active = 0;
    logic [15:0] run_addr = '0;
    int          run_len = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return 8'(a * 16'd29 + {8'd0, salt}) ^ a[15:8];
    endfunction

    function automatic logic [23:0] exp_word(input logic [15:0] base, input int w);
        logic [15:0] e;
        e = base + 16'(3 * w);
        return {mem_byte(e), mem_byte(e + 16'd1), mem_byte(e + 16'd2)};
    endfunction

    assign ext_data = mem_byte(ext_addr);

    bytemem_boot_dma uut (
        .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ext_addr(ext_addr), .ext_data(ext_data), .ext_rd(ext_rd),
        .pm_addr(pm_addr), .pm_wdata(pm_wdata), .pm_we(pm_we),
        .core_hold(core_hold), .core_restart(core_restart),
        .irq_pend(irq_pend), .irq_ack(irq_ack)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(posedge clk); #1;
        cfg_addr = a;
        @(negedge clk);
        v = cfg_rdata;
    endtask

    task automatic wait_irq();
        int guard = 0;
        while (!irq_pend && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    task automatic ack_irq();
        @(posedge clk); #1; irq_ack = 1'b1;
        @(posedge clk); #1; irq_ack = 1'b0;
        @(negedge clk);
        chk(irq_pend == 1'b0, "R9 ack clears irq", int'(irq_pend), 0);
    endtask

    // Monitor: strobe length per byte (R3) and packed word writes (R4).
    always @(negedge clk) begin
        if (!rst_n) begin
            run_active = 0;
        end else begin
            if (ext_rd) begin
                if (run_active && ext_addr == run_addr) begin
                    run_len++;
                end else begin
                    if (run_active) chk(run_len == exp_wait + 1, "R3 strobe length", run_len, exp_wait + 1);
                    run_addr = ext_addr;
                    run_len = 1;
                    run_active = 1;
                end
            end else if (run_active) begin
                chk(run_len == exp_wait + 1, "R3 strobe length", run_len, exp_wait + 1);
                run_active = 0;
            end
            if (pm_we) begin
                chk(pm_addr == exp_int + 14'(widx), "R4 write address", int'(pm_addr), int'(exp_int + 14'(widx)));
                chk(pm_wdata == exp_word(exp_ext, widx), "R4 packed word", int'(pm_wdata), int'(exp_word(exp_ext, widx)));
                widx++;
            end
            if (core_restart) restart_cnt++;
            if (core_hold) hold_seen = 1;
        end
    end

    // Software transfer; meddle writes registers mid-transfer (R8).
    task automatic run_xfer(input bit ctx, input int w, input logic [13:0] ib,
                            input logic [15:0] eb, input int n, input bit meddle);
        logic [15:0] v;
        wr(3'd5, {15'd0, ctx});
        wr(3'd3, 16'(w));
        wr(3'd0, {2'd0, ib});
        wr(3'd1, eb);
        exp_wait = w; exp_int = ib; exp_ext = eb;
        widx = 0; restart_cnt = 0; hold_seen = 0;
        wr(3'd4, 16'(n));
        @(negedge clk);
        chk(core_hold == ctx, "R7 hold follows context bit", int'(core_hold), int'(ctx));
        if (meddle) begin
            wr(3'd4, 16'd9);
            wr(3'd0, 16'h0100);
        end
        wait_irq();
        chk(widx == n, "R8 R7 words written", widx, n);
        chk(restart_cnt == int'(ctx), "R6 R7 restart pulses", restart_cnt, int'(ctx));
        chk(hold_seen == ctx, "R7 hold during transfer", int'(hold_seen), int'(ctx));
        chk(core_hold == 1'b0, "R6 hold released", int'(core_hold), 0);
        rd(3'd0, v);
        chk(v == {2'd0, ib + 14'(n)}, "R4 R8 final internal address", int'(v), int'({2'd0, ib + 14'(n)}));
        rd(3'd1, v);
        chk(v == eb + 16'(3 * n), "R3 final external address", int'(v), int'(eb + 16'(3 * n)));
        rd(3'd4, v);
        chk(v == 16'd0, "R4 count at zero", int'(v), 0);
        ack_irq();
    endtask

    // Watchdog: an expired run counts as a failure and still summarises.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int unsigned seed;
        seed = $urandom(32'd5150);
        salt = 8'($urandom);

        // Reset boot, mode 00 (R1, R5, R6).
        rst_n = 1'b0; boot_mode = 2'b00;
        exp_wait = 7; exp_int = '0; exp_ext = '0; widx = 0; restart_cnt = 0;
        repeat (3) @(posedge clk);
        #1 cfg_addr = 3'd4;
        @(negedge clk);
        chk(cfg_rdata == 16'd32, "R1 reset word count", int'(cfg_rdata), 32);
        chk(core_hold == 1'b1, "R1 core held at reset", int'(core_hold), 1);
        #1 cfg_addr = 3'd3;
        #1 chk(cfg_rdata == 16'd7, "R1 reset wait count", int'(cfg_rdata), 7);
        #1 cfg_addr = 3'd5;
        #1 chk(cfg_rdata == 16'd1, "R1 reset context bit", int'(cfg_rdata), 1);
        #1 cfg_addr = 3'd2;
        #1 chk(cfg_rdata == 16'd0, "R10 R1 reset control fields", int'(cfg_rdata), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        wait_irq();
        chk(widx == 32, "R5 boot words", widx, 32);
        chk(restart_cnt == 1, "R6 boot restart pulse", restart_cnt, 1);
        chk(core_hold == 1'b0, "R6 core released", int'(core_hold), 0);
        chk(irq_pend == 1'b1, "R6 irq pending", int'(irq_pend), 1);
        rd(3'd0, v);
        chk(v == 16'h0020, "R5 internal address end", int'(v), 32'h20);
        rd(3'd1, v);
        chk(v == 16'h0060, "R5 external address end", int'(v), 32'h60);
        rd(3'd4, v);
        chk(v == 16'h0000, "R5 word count end", int'(v), 0);
        ack_irq();

        // Reset with nonzero mode (R2), then a zero-count write (R8).
        @(posedge clk); #1 rst_n = 1'b0; boot_mode = 2'b01;
        repeat (2) @(posedge clk); #1 rst_n = 1'b1;
        widx = 0;
        repeat (60) @(posedge clk);
        @(negedge clk);
        chk(core_hold == 1'b0, "R2 no hold", int'(core_hold), 0);
        chk(widx == 0, "R2 no transfer", widx, 0);
        rd(3'd4, v);
        chk(v == 16'd0, "R2 zero count", int'(v), 0);
        wr(3'd4, 16'd0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(widx == 0 && irq_pend == 1'b0, "R8 zero count starts nothing", widx, 0);

        // Control field readback (R10).
        wr(3'd2, 16'h03FF);
        rd(3'd2, v);
        chk(v == 16'h03FF, "R10 control readback", int'(v), 32'h3FF);

        // Directed corners.
        run_xfer(1'b1, 0, 14'h3FFE, 16'hFFFE, 1, 1'b0);
        run_xfer(1'b0, 7, 14'h0010, 16'h1000, 4, 1'b1);
        run_xfer(1'b1, 3, 14'h0000, 16'h0000, 2, 1'b1);

        // Random transfers.
        for (int i = 0; i < 8; i++) begin
            run_xfer(1'($urandom), int'($urandom % 8), 14'($urandom), 16'($urandom),
                     1 + int'($urandom % 6), 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule